// File: doc/BRIEF.md
# Multi-Page-Size Micro Translation Cache

This block is a small, fully associative translation cache that sits in front of a page-table walker. It turns a 39-bit virtual address into a 56-bit physical address under a three-level page-table scheme. Every entry can describe a 4 KB, 2 MB or 1 GB page. The tag compare and the physical-address merge are masked per entry according to that size. A lookup returns its answer one clock later: a hit with the translated address, a permission fault, or a miss.

A miss raises a refill request that carries the virtual page number. The request holds until an external walker delivers an entry on the fill port. A new entry goes into the lowest-numbered empty slot. When every slot is full, a round-robin pointer picks the victim. A flush input drops every entry in one cycle.

Top module: `mpage_utlb`

## Requirements
- R1: A lookup (`lk_valid`=1) gets its answer in the next cycle. A hit on a 4 KB entry whose stored page number equals `lk_vaddr[38:12]` returns `res_hit`=1 and `res_paddr` = {stored 44-bit page number, `lk_vaddr[11:0]`}.
- R2: An entry filled with `fill_size`=1 (2 MB) ignores `lk_vaddr[20:12]` in its compare, and those bits pass straight into `res_paddr[20:12]`. A difference in any higher bit is a miss.
- R3: An entry filled with `fill_size`=2 (1 GB) ignores `lk_vaddr[29:12]` in its compare, and those bits pass straight into `res_paddr[29:12]`.
- R4: `lk_acc` encodes the access as 0 = read, 1 = write, 2 = execute. `fill_perm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. A matching lookup whose access is not allowed reports `res_fault`=1, with `res_hit`=0 and `res_miss`=0.
- R5: A miss sets `res_miss`=1, and in the same cycle `refill_req`=1 with `refill_vpn` = the missed `lk_vaddr[38:12]`. The request and its page number hold until a fill arrives, and later misses do not replace them. A miss in the same cycle as a fill raises a new request.
- R6: A fill (`fill_valid`=1) drops an outstanding request. The new entry is used from the next cycle. It goes to the lowest-numbered empty slot, so no valid entry is evicted while any slot is empty.
- R7: When all slots are valid, each fill replaces the slot named by a pointer. The pointer starts at slot 0 after reset and advances by one, modulo the depth, on each such replacement.
- R8: `flush` clears every entry in one cycle. A lookup in the same cycle reports a miss, and lookups after it miss until entries are filled again.
- R9: After reset, no entry is valid, every result output is 0 and `refill_req` is 0.
- R10: At most one of `res_hit`, `res_fault` and `res_miss` is 1. All three are 0 in the cycle after a cycle with no lookup.
- R11: A lookup in the same cycle as a fill is answered from the contents held before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 39 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| fill_valid | input | 1 | Walker delivers an entry |
| fill_vpn | input | 27 | Virtual page number of the entry |
| fill_ppn | input | 44 | Physical page number of the entry |
| fill_size | input | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_perm | input | 3 | Permissions {X, W, R} |
| res_hit | output | 1 | Translation succeeded |
| res_fault | output | 1 | Entry matched but the access is not permitted |
| res_miss | output | 1 | No entry matched |
| res_paddr | output | 56 | Translated physical address |
| refill_req | output | 1 | Refill request to the walker |
| refill_vpn | output | 27 | Page number to be walked |

## Verification
The bench builds the block with its default parameters: 8 slots, a 39-bit virtual and a 56-bit physical address, 12 offset bits and 9 bits per level. With these values the 2 MB and 1 GB mask edges fall at page-number bits 8 and 17, and the bench probes addresses just inside and just past them. Eight slots are few enough to fill completely within a short run. That lets the bench watch the victim pointer wrap from the invalid-first phase into round-robin replacement, across two successive evictions.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  // perm bit 0 = read, 1 = write, 2 = execute
  function automatic logic perm_ok(input logic [1:0] acc, input logic [2:0] perm);
    case (acc_e'(acc))
      ACC_RD:  perm_ok = perm[0];
      ACC_WR:  perm_ok = perm[1];
      ACC_EX:  perm_ok = perm[2];
      default: perm_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/utlb_entry.sv
module utlb_entry
  import utlb_pkg::*;
#(
  parameter int VPN_W    = 27,
  parameter int PPN_W    = 44,
  parameter int LVL_BITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_size,
  input  logic [2:0]       wr_perm,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             valid_o,
  output logic             match_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [2:0]       perm_o
);

  localparam int PAD = PPN_W - VPN_W;

  logic             vld_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  pg_size_e         size_q;
  logic [2:0]       perm_q;
  logic [VPN_W-1:0] ign;
  logic [PPN_W-1:0] ign_w;

  always_ff @(posedge clk) begin
    if (rst)             vld_q <= 1'b0;
    else if (flush)      vld_q <= 1'b0;
    else if (wr_en)      vld_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q  <= wr_vpn;
      ppn_q  <= wr_ppn;
      size_q <= pg_size_e'(wr_size);
      perm_q <= wr_perm;
    end
  end

  // low page-number bits that act as page offset for large pages
  always_comb begin
    case (size_q)
      PG_2M:   ign = {{(VPN_W-LVL_BITS){1'b0}}, {LVL_BITS{1'b1}}};
      PG_1G:   ign = {{(VPN_W-2*LVL_BITS){1'b0}}, {(2*LVL_BITS){1'b1}}};
      default: ign = '0;
    endcase
  end

  assign ign_w   = {{PAD{1'b0}}, ign};
  assign valid_o = vld_q;
  assign match_o = vld_q && (((vpn_q ^ lk_vpn) & ~ign) == '0);
  assign ppn_o   = (ppn_q & ~ign_w) | ({{PAD{1'b0}}, lk_vpn} & ign_w);
  assign perm_o  = perm_q;

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int N_ENTRY = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_ENTRY-1:0] valid_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] first_free;
  logic             all_valid;

  always_comb begin
    first_free = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (!valid_i[i]) first_free = IDX_W'(i);
    end
  end

  assign all_valid = &valid_i;
  assign idx_o     = all_valid ? ptr_q : first_free;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (adv_i && all_valid) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

endmodule

// File: rtl/mpage_utlb.sv
module mpage_utlb
  import utlb_pkg::*;
#(
  parameter int N_ENTRY  = 8,
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PG_OFF   = 12,
  parameter int LVL_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  input  logic [1:0]           lk_acc,
  input  logic                 fill_valid,
  input  logic [VA_W-PG_OFF-1:0] fill_vpn,
  input  logic [PA_W-PG_OFF-1:0] fill_ppn,
  input  logic [1:0]           fill_size,
  input  logic [2:0]           fill_perm,
  output logic                 res_hit,
  output logic                 res_fault,
  output logic                 res_miss,
  output logic [PA_W-1:0]      res_paddr,
  output logic                 refill_req,
  output logic [VA_W-PG_OFF-1:0] refill_vpn
);

  localparam int VPN_W = VA_W - PG_OFF;
  localparam int PPN_W = PA_W - PG_OFF;
  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [VPN_W-1:0]   lk_vpn;
  logic [N_ENTRY-1:0] ent_valid;
  logic [N_ENTRY-1:0] ent_match;
  logic [PPN_W-1:0]   ent_ppn  [N_ENTRY];
  logic [2:0]         ent_perm [N_ENTRY];
  logic [IDX_W-1:0]   victim;
  logic               fill_go;
  logic               any_match;
  logic [PPN_W-1:0]   ppn_sel;
  logic [2:0]         perm_sel;
  logic               pass;
  logic               found;
  logic               miss_now;

  assign lk_vpn  = lk_vaddr[VA_W-1:PG_OFF];
  assign fill_go = fill_valid && !flush;

  utlb_victim #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .valid_i (ent_valid),
    .adv_i   (fill_go),
    .idx_o   (victim)
  );

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    utlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .LVL_BITS(LVL_BITS)) u_ent (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .wr_en   (fill_go && (victim == IDX_W'(g))),
      .wr_vpn  (fill_vpn),
      .wr_ppn  (fill_ppn),
      .wr_size (fill_size),
      .wr_perm (fill_perm),
      .lk_vpn  (lk_vpn),
      .valid_o (ent_valid[g]),
      .match_o (ent_match[g]),
      .ppn_o   (ent_ppn[g]),
      .perm_o  (ent_perm[g])
    );
  end

  always_comb begin
    ppn_sel  = '0;
    perm_sel = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (ent_match[i]) begin
        ppn_sel  = ppn_sel | ent_ppn[i];
        perm_sel = perm_sel | ent_perm[i];
      end
    end
  end

  assign any_match = |ent_match;
  assign pass      = perm_ok(lk_acc, perm_sel);
  assign found     = lk_valid && !flush && any_match;
  assign miss_now  = lk_valid && (flush || !any_match);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_miss  <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_hit   <= found && pass;
      res_fault <= found && !pass;
      res_miss  <= miss_now;
      res_paddr <= found ? {ppn_sel, lk_vaddr[PG_OFF-1:0]} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refill_req <= 1'b0;
      refill_vpn <= '0;
    end else if (miss_now && (!refill_req || fill_valid)) begin
      refill_req <= 1'b1;
      refill_vpn <= lk_vpn;
    end else if (fill_valid) begin
      refill_req <= 1'b0;
    end
  end

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
  parameter int PA_W  = 56,
  parameter int VPN_W = 27
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lk_valid,
  input logic             fill_valid,
  input logic             res_hit,
  input logic             res_fault,
  input logic             res_miss,
  input logic [PA_W-1:0]  res_paddr,
  input logic             refill_req,
  input logic [VPN_W-1:0] refill_vpn
);

  // R10
  excl_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_hit, res_fault, res_miss}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !(res_hit || res_fault || res_miss));

  // R1
  lookup_answer_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (res_hit || res_fault || res_miss));

  // R8
  flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid) |=> res_miss);

  // R5
  refill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !fill_valid) |=> (refill_req && $stable(refill_vpn)));

  // R5
  miss_raise_chk: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (refill_req && res_paddr == '0));

  // R6
  fill_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !lk_valid) |=> !refill_req);

endmodule

bind mpage_utlb utlb_chk #(.PA_W(PA_W), .VPN_W(VA_W - PG_OFF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .fill_valid (fill_valid),
  .res_hit    (res_hit),
  .res_fault  (res_fault),
  .res_miss   (res_miss),
  .res_paddr  (res_paddr),
  .refill_req (refill_req),
  .refill_vpn (refill_vpn)
);

// File: tb/mpage_utlb_tb.sv
`timescale 1ns/1ps
module mpage_utlb_tb;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] K_HIT = 2'd1, K_FLT = 2'd2, K_MIS = 2'd3;
  localparam int NV = 11;
  // {vaddr[38:0], acc[1:0], kind[1:0], paddr[55:0]}
  localparam logic [98:0] VEC [NV] = '{
    {27'h0001234, 12'h5A5, RD, K_HIT, 44'h00000ABCDE, 12'h5A5},
    {27'h0001234, 12'h5A5, WR, K_HIT, 44'h00000ABCDE, 12'h5A5},
    {27'h0001234, 12'h5A5, EX, K_FLT, 56'h0},
    {27'h00022FF, 12'h321, RD, K_HIT, 44'h0000123400 | 44'h0FF, 12'h321},
    {27'h00022FF, 12'h321, EX, K_HIT, 44'h0000123400 | 44'h0FF, 12'h321},
    {27'h00022FF, 12'h321, WR, K_FLT, 56'h0},
    {27'h0002400, 12'h000, RD, K_MIS, 56'h0},
    {27'h043FFFF, 12'hFFF, EX, K_HIT, 44'h00ABC00000 | 44'h3FFFF, 12'hFFF},
    {27'h0400000, 12'h000, RD, K_FLT, 56'h0},
    {27'h0001235, 12'h010, RD, K_MIS, 56'h0},
    {27'h0440000, 12'h000, EX, K_MIS, 56'h0}
  };
  localparam string VTAG [NV] = '{"R1","R1","R4","R2","R2","R4","R2","R3","R3","R1","R3"};

  logic        clk = 1'b0;
  logic        rst, flush, lk_valid, fill_valid;
  logic [38:0] lk_vaddr;
  logic [1:0]  lk_acc, fill_size;
  logic [26:0] fill_vpn;
  logic [43:0] fill_ppn;
  logic [2:0]  fill_perm;
  logic        res_hit, res_fault, res_miss, refill_req;
  logic [55:0] res_paddr;
  logic [26:0] refill_vpn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mpage_utlb u_dut (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_size(fill_size), .fill_perm(fill_perm), .res_hit(res_hit), .res_fault(res_fault),
    .res_miss(res_miss), .res_paddr(res_paddr), .refill_req(refill_req), .refill_vpn(refill_vpn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_now();
    return res_hit ? K_HIT : res_fault ? K_FLT : res_miss ? K_MIS : 2'd0;
  endfunction

  task automatic fill(input logic [26:0] vpn, input logic [43:0] ppn,
                      input logic [1:0] sz, input logic [2:0] pm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_size = sz; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input string tag, input logic [38:0] va, input logic [1:0] acc,
                      input logic [1:0] kind, input logic [55:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(tag, 64'(kind_now()), 64'(kind));
    if (kind == K_HIT) chk(tag, 64'(res_paddr), 64'(pa));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
    lk_vaddr = '0; lk_acc = '0; fill_vpn = '0; fill_ppn = '0; fill_size = '0; fill_perm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state, R10 idle quiet
    chk("R9", 64'({res_hit, res_fault, res_miss}), 64'd0);
    chk("R9", 64'(refill_req), 64'd0);
    chk("R9", 64'(res_paddr), 64'd0);
    chk("R10", 64'(kind_now()), 64'd0);

    fill(27'h0001234, 44'h00000ABCDE, 2'd0, 3'b011);
    fill(27'h0002200, 44'h0000123400, 2'd1, 3'b101);
    fill(27'h0400000, 44'h00ABC00000, 2'd2, 3'b100);

    for (int i = 0; i < NV; i++)
      look(VTAG[i], VEC[i][98:60], VEC[i][59:58], VEC[i][57:56], VEC[i][55:0]);

    // R10: no lookup after a result -> quiet
    @(negedge clk);
    chk("R10", 64'(kind_now()), 64'd0);
    // R5: first miss held, later misses ignored
    chk("R5", 64'(refill_req), 64'd1);
    chk("R5", 64'(refill_vpn), 64'h0002400);

    // R6: fill clears request, new entry usable
    fill(27'h0001235, 44'h1111, 2'd0, 3'b111);
    chk("R6", 64'(refill_req), 64'd0);
    look("R6", {27'h0001235, 12'h010}, RD, K_HIT, {44'h1111, 12'h010});

    // R11: lookup with same-cycle fill sees old contents
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {27'h0005000, 12'h0}; lk_acc = RD;
    fill_valid = 1'b1; fill_vpn = 27'h0005000; fill_ppn = 44'h5555; fill_size = 2'd0; fill_perm = 3'b001;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    chk("R11", 64'(kind_now()), 64'(K_MIS));
    chk("R5", 64'({refill_req, refill_vpn}), {36'd0, 1'b1, 27'h0005000});
    look("R11", {27'h0005000, 12'h004}, RD, K_HIT, {44'h5555, 12'h004});

    // R6: remaining empty slots used before any eviction
    fill(27'h0006000, 44'h6666, 2'd0, 3'b001);
    fill(27'h0007000, 44'h7777, 2'd0, 3'b001);
    fill(27'h0008000, 44'h8888, 2'd0, 3'b001);
    look("R6", {27'h0001234, 12'h001}, RD, K_HIT, {44'h00000ABCDE, 12'h001});

    // R7: round-robin from slot 0, then slot 1
    fill(27'h0009000, 44'h9999, 2'd0, 3'b001);
    look("R7", {27'h0001234, 12'h001}, RD, K_MIS, 56'h0);
    look("R7", {27'h0009000, 12'h002}, RD, K_HIT, {44'h9999, 12'h002});
    fill(27'h000A000, 44'hAAAA, 2'd0, 3'b001);
    look("R7", {27'h00022FF, 12'h321}, RD, K_MIS, 56'h0);
    look("R7", {27'h0400000, 12'h000}, EX, K_HIT, {44'h00ABC00000, 12'h000});
    look("R7", {27'h0001235, 12'h010}, RD, K_HIT, {44'h1111, 12'h010});

    // R8: flush with same-cycle lookup, then everything misses
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; lk_vaddr = {27'h0009000, 12'h0}; lk_acc = RD;
    @(negedge clk);
    flush = 1'b0; lk_valid = 1'b0;
    chk("R8", 64'(kind_now()), 64'(K_MIS));
    look("R8", {27'h000A000, 12'h0}, RD, K_MIS, 56'h0);
    look("R8", {27'h0001235, 12'h0}, RD, K_MIS, 56'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule